// File: doc/BRIEF.md
# Thermal throttle controller

This block takes the operating point away from software when an on-die sensor reports that the die is too hot. In normal running it forwards software operating-point requests to the transition sequencer over a request/acknowledge handshake. A request that arrives while a transition is in flight waits until the current one has finished. When the hot indication has held steady for a programmable number of samples, the block asks the sequencer to move to a programmable low point. It keeps the software-requested point as the restore target.

Once the sequencer acknowledges the move down, the block waits a fixed number of cycles and then samples the sensor again. If the die is still hot, it stays at the low point and starts a new wait. If the die has cooled, it requests the restore target and hands control back to software. Software requests made while the block is throttled replace the restore target but are not applied until the restore. Both the throttle-down and the restore set a sticky interrupt status bit. If the sequencer reports that the move down failed, the block falls back to clock-duty throttling through a separate enable output.

Top module: `therm_guard`

## Requirements
- R1: During and right after a synchronous reset, tr_req_o, throttled_o, duty_en_o, irq_o and irq_stat_o are all 0.
- R2: Outside throttling, a software request whose point differs from the applied point is issued on tr_req_o/tr_pt_o. The request and its point are held until tr_ack_i. A software request made while a request is outstanding is issued after the acknowledge, and the latest such request wins.
- R3: Throttling begins only after hot_i has been high on cfg_qual_i consecutive clock edges, with a value of 0 treated as 1. A low sample restarts the count.
- R4: On qualified heat, with no transition outstanding, throttled_o rises and a request for cfg_low_pt_i is issued in the same cycle. The point software requested is kept as the restore target.
- R5: After the down acknowledge, exactly WAIT_CYC cycles pass with no request outstanding before the temperature is judged again.
- R6: If hot_i is low at the end of the wait, a request for the restore target is issued. throttled_o falls when that request is acknowledged.
- R7: If hot_i is high at the end of the wait, the block stays throttled with no request and starts a new wait of WAIT_CYC cycles.
- R8: irq_stat_o bit 0 is set by the acknowledge of the down transition, and bit 1 by the acknowledge of the restore. irq_o is high while either bit is set.
- R9: Writing 1 to a bit of irq_clr_i clears the matching status bit in the next cycle. A set in the same cycle wins over the clear.
- R10: A down acknowledge with tr_fail_i high raises duty_en_o. duty_en_o stays high until the restore is acknowledged.
- R11: While throttled, software requests issue no transition. The latest of them becomes the restore target.
- R12: A successful acknowledge updates the applied point. Outside throttling, a failed acknowledge leaves the applied point unchanged, so the request is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | Over-temperature indication from the sensor (synchronous) |
| sw_req_i | input | 1 | Software writes a new operating point |
| sw_pt_i | input | PT_W | Operating point written by software |
| cfg_low_pt_i | input | PT_W | Low point used while throttled |
| cfg_qual_i | input | QUAL_W | Consecutive hot samples needed to throttle |
| irq_clr_i | input | 2 | Write-1-to-clear for the status bits (bit 0 down, bit 1 restore) |
| tr_req_o | output | 1 | Transition request to the sequencer |
| tr_pt_o | output | PT_W | Requested operating point |
| tr_ack_i | input | 1 | Sequencer has finished the transition |
| tr_fail_i | input | 1 | Qualifies tr_ack_i: the transition failed |
| throttled_o | output | 1 | Operating point is under thermal control |
| duty_en_o | output | 1 | Clock duty-cycle throttling enable |
| irq_o | output | 1 | Interrupt, high while any status bit is set |
| irq_stat_o | output | 2 | Sticky status: bit 0 throttle-down, bit 1 restore |

## Verification
The bench drives the block with several kinds of heat. Short hot bursts shorter than the qualification count must not throttle, which separates counting consecutive samples from counting total hot samples. Heat that stays on across a wait must restart the wait rather than restore, and heat that drops right after the throttle pins down the exact length of the wait. A count of zero checks that it qualifies on a single sample. Failed acknowledges are injected both on the down transition and in normal running, which separates the duty-throttle fallback from the retry of a plain request. A software write made during the hold shows that the restore target moves while no transition is issued.

// File: rtl/therm_pkg.sv
package therm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_HOLD = 2'd2,
    ST_UP   = 2'd3
  } thr_state_e;

  localparam int unsigned N_EVT   = 2;
  localparam int unsigned EVT_DOWN = 0;
  localparam int unsigned EVT_UP   = 1;
endpackage

// File: rtl/hot_qualifier.sv
module hot_qualifier #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hot_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hot_q_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   need;
  logic [CNT_W:0]   seen;

  // a limit of zero behaves as one sample
  assign need    = (limit_i == '0) ? (CNT_W+1)'(1) : {1'b0, limit_i};
  assign seen    = {1'b0, run_cnt} + (CNT_W+1)'(1);
  assign hot_q_o = hot_i && (seen >= need);

  always_ff @(posedge clk) begin
    if (rst)               run_cnt <= '0;
    else if (!hot_i)       run_cnt <= '0;
    else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
  end

  // R3: a cool sample restarts the run
  a_r3_run_restart: assert property (@(posedge clk) disable iff (rst)
    !hot_i |=> run_cnt == '0);
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned WAIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned TW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

  logic [TW-1:0] cnt;

  assign expire_o = run_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || expire_o) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  // R5: the count never passes the end of the window
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N_EV = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_EV-1:0] set_i,
  input  logic [N_EV-1:0] clr_i,
  output logic [N_EV-1:0] stat_o,
  output logic            irq_o
);
  logic [N_EV-1:0] stat_nx;

  for (genvar g = 0; g < N_EV; g++) begin : g_bit
    assign stat_nx[g] = set_i[g] | (stat_o[g] & ~clr_i[g]);

    always_ff @(posedge clk) begin
      if (rst) stat_o[g] <= 1'b0;
      else     stat_o[g] <= stat_nx[g];
    end

    // R9: write-one clears unless a new event lands together with it
    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !stat_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |stat_nx;
  end

  // R8: the line follows the status bits
  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == (stat_o != '0));
endmodule

// File: rtl/therm_guard.sv
module therm_guard
  import therm_pkg::*;
#(
  parameter int unsigned PT_W     = 4,
  parameter int unsigned QUAL_W   = 4,
  parameter int unsigned WAIT_CYC = 1000,
  parameter logic [PT_W-1:0] RST_PT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hot_i,
  input  logic              sw_req_i,
  input  logic [PT_W-1:0]   sw_pt_i,
  input  logic [PT_W-1:0]   cfg_low_pt_i,
  input  logic [QUAL_W-1:0] cfg_qual_i,
  input  logic [N_EVT-1:0]  irq_clr_i,
  output logic              tr_req_o,
  output logic [PT_W-1:0]   tr_pt_o,
  input  logic              tr_ack_i,
  input  logic              tr_fail_i,
  output logic              throttled_o,
  output logic              duty_en_o,
  output logic              irq_o,
  output logic [N_EVT-1:0]  irq_stat_o
);
  thr_state_e       state;
  logic [PT_W-1:0]  want;     // software target, also the restore target
  logic [PT_W-1:0]  want_nx;
  logic [PT_W-1:0]  applied;  // last point confirmed by the sequencer
  logic             hot_q;
  logic             expire;
  logic             ack_v;
  logic [N_EVT-1:0] ev_set;

  assign want_nx = sw_req_i ? sw_pt_i : want;
  assign ack_v   = tr_ack_i && tr_req_o;

  always_comb begin
    ev_set           = '0;
    ev_set[EVT_DOWN] = (state == ST_DOWN) && ack_v;
    ev_set[EVT_UP]   = (state == ST_UP)   && ack_v;
  end

  hot_qualifier #(.CNT_W(QUAL_W)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .hot_i   (hot_i),
    .limit_i (cfg_qual_i),
    .hot_q_o (hot_q)
  );

  hold_timer #(.WAIT_CYC(WAIT_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .run_i    (state == ST_HOLD),
    .expire_o (expire)
  );

  irq_status #(.N_EV(N_EVT)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_i  (ev_set),
    .clr_i  (irq_clr_i),
    .stat_o (irq_stat_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      want      <= RST_PT;
      applied   <= RST_PT;
      tr_req_o  <= 1'b0;
      tr_pt_o   <= RST_PT;
      duty_en_o <= 1'b0;
    end else begin
      want <= want_nx;
      unique case (state)
        ST_RUN: begin
          if (tr_req_o) begin
            if (ack_v) begin
              tr_req_o <= 1'b0;
              if (!tr_fail_i) applied <= tr_pt_o;
            end
          end else if (hot_q) begin
            state    <= ST_DOWN;
            tr_req_o <= 1'b1;
            tr_pt_o  <= cfg_low_pt_i;
          end else if (want_nx != applied) begin
            tr_req_o <= 1'b1;
            tr_pt_o  <= want_nx;
          end
        end
        ST_DOWN: begin
          if (ack_v) begin
            tr_req_o <= 1'b0;
            state    <= ST_HOLD;
            if (tr_fail_i) duty_en_o <= 1'b1;
            else           applied   <= tr_pt_o;
          end
        end
        ST_HOLD: begin
          if (expire && !hot_i) begin
            state    <= ST_UP;
            tr_req_o <= 1'b1;
            tr_pt_o  <= want_nx;
          end
        end
        ST_UP: begin
          if (ack_v) begin
            tr_req_o  <= 1'b0;
            duty_en_o <= 1'b0;
            state     <= ST_RUN;
            if (!tr_fail_i) applied <= tr_pt_o;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign throttled_o = (state != ST_RUN);

  // R2: a pending request keeps its point until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (tr_req_o && !tr_ack_i) |=> (tr_req_o && $stable(tr_pt_o)));

  // R3: throttling only starts on a hot sample
  a_r3_hot_seen: assert property (@(posedge clk) disable iff (rst)
    $rose(throttled_o) |-> $past(hot_i));

  // R4: entering throttle requests the programmed low point
  a_r4_low_point: assert property (@(posedge clk) disable iff (rst)
    $rose(throttled_o) |-> (tr_req_o && tr_pt_o == $past(cfg_low_pt_i)));

  // R8: status bits are set only by an acknowledge
  a_r8_down_evt: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat_o[EVT_DOWN]) |-> $past(tr_ack_i));
  a_r8_up_evt: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat_o[EVT_UP]) |-> $past(tr_ack_i));

  // R10: fallback starts only from a failed acknowledge
  a_r10_duty_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(duty_en_o) |-> $past(tr_ack_i && tr_fail_i));

  // R11: nothing is requested while holding at the low point
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> !tr_req_o);
endmodule

// File: tb/test_therm_guard.sv
module test_therm_guard;
  localparam int PT_W = 4;
  localparam int QUAL_W = 4;
  localparam int WAIT_CYC = 16;
  localparam int LOW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hot_i = 1'b0;
  logic sw_req_i = 1'b0;
  logic [PT_W-1:0] sw_pt_i = '0;
  logic [PT_W-1:0] cfg_low_pt_i = PT_W'(LOW);
  logic [QUAL_W-1:0] cfg_qual_i = QUAL_W'(3);
  logic [1:0] irq_clr_i = '0;
  logic tr_req_o;
  logic [PT_W-1:0] tr_pt_o;
  logic tr_ack_i = 1'b0;
  logic tr_fail_i = 1'b0;
  logic throttled_o, duty_en_o, irq_o;
  logic [1:0] irq_stat_o;

  therm_guard #(.PT_W(PT_W), .QUAL_W(QUAL_W), .WAIT_CYC(WAIT_CYC)) i_therm_guard (
    .clk(clk), .rst(rst), .hot_i(hot_i), .sw_req_i(sw_req_i), .sw_pt_i(sw_pt_i),
    .cfg_low_pt_i(cfg_low_pt_i), .cfg_qual_i(cfg_qual_i), .irq_clr_i(irq_clr_i),
    .tr_req_o(tr_req_o), .tr_pt_o(tr_pt_o), .tr_ack_i(tr_ack_i), .tr_fail_i(tr_fail_i),
    .throttled_o(throttled_o), .duty_en_o(duty_en_o), .irq_o(irq_o), .irq_stat_o(irq_stat_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit fail_mode = 1'b0;
  int seq_cnt = 0;
  bit done = 1'b0;

  // reference model state
  int m_state = 0;  // 0 run, 1 down, 2 hold, 3 up
  int m_want = 0, m_cur = 0, m_pt = 0, m_qcnt = 0, m_tmr = 0;
  bit m_req = 0, m_duty = 0, m_irq = 0;
  bit [1:0] m_stat = 0;

  always @(posedge clk) begin
    int wn, need;
    bit hq, ackv;
    bit [1:0] setv;
    if (rst) begin
      m_state = 0; m_want = 0; m_cur = 0; m_pt = 0; m_qcnt = 0; m_tmr = 0;
      m_req = 0; m_duty = 0; m_irq = 0; m_stat = 0;
    end else begin
      wn = sw_req_i ? int'(sw_pt_i) : m_want;
      need = (cfg_qual_i == 0) ? 1 : int'(cfg_qual_i);
      hq = hot_i && (m_qcnt + 1 >= need);
      if (!hot_i) m_qcnt = 0; else if (m_qcnt < 15) m_qcnt++;
      ackv = tr_ack_i && m_req;
      setv = 0;
      case (m_state)
        0: begin
          if (m_req) begin
            if (ackv) begin m_req = 0; if (!tr_fail_i) m_cur = m_pt; end
          end else if (hq) begin
            m_state = 1; m_req = 1; m_pt = int'(cfg_low_pt_i);
          end else if (wn != m_cur) begin
            m_req = 1; m_pt = wn;
          end
        end
        1: if (ackv) begin
          m_req = 0; m_state = 2; m_tmr = 0; setv[0] = 1;
          if (tr_fail_i) m_duty = 1; else m_cur = m_pt;
        end
        2: begin
          if (m_tmr == WAIT_CYC - 1) begin
            m_tmr = 0;
            if (!hot_i) begin m_state = 3; m_req = 1; m_pt = wn; end
          end else m_tmr++;
        end
        default: if (ackv) begin
          m_req = 0; m_duty = 0; m_state = 0; setv[1] = 1;
          if (!tr_fail_i) m_cur = m_pt;
        end
      endcase
      m_stat = (m_stat & ~irq_clr_i) | setv;
      m_irq = (m_stat != 0);
      m_want = wn;
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, then act as the sequencer
  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp("tr_req_o", int'(tr_req_o), int'(m_req));
      cmp("tr_pt_o", int'(tr_pt_o), m_pt);
      cmp("throttled_o", int'(throttled_o), int'(m_state != 0));
      cmp("duty_en_o", int'(duty_en_o), int'(m_duty));
      cmp("irq_o", int'(irq_o), int'(m_irq));
      cmp("irq_stat_o", int'(irq_stat_o), int'(m_stat));
    end
    if (tr_ack_i) begin
      tr_ack_i = 0; tr_fail_i = 0; seq_cnt = 0;
    end else if (tr_req_o) begin
      seq_cnt++;
      if (seq_cnt >= 2) begin tr_ack_i = 1; tr_fail_i = fail_mode; end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_thr(bit v);
    for (int i = 0; i < 300 && throttled_o != v; i++) @(negedge clk);
  endtask

  task automatic wait_req(bit v);
    for (int i = 0; i < 300 && tr_req_o != v; i++) @(negedge clk);
  endtask

  task automatic sw_write(int pt);
    sw_req_i = 1; sw_pt_i = PT_W'(pt);
    tick(1);
    sw_req_i = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s act=running exp=finished", tag);
    finish_run();
  end

  initial begin
    int cnt;
    tick(3);
    tag = "R1";
    cmp("reset req", int'(tr_req_o), 0);
    cmp("reset stat", int'(irq_stat_o), 0);
    cmp("reset duty", int'(duty_en_o), 0);
    rst = 0;
    tick(1);
    cmp("post-reset throttled", int'(throttled_o), 0);
    cmp("post-reset irq", int'(irq_o), 0);

    tag = "R2";
    sw_write(9);
    tick(6);
    cmp("applied point", int'(tr_pt_o), 9);
    cmp("request done", int'(tr_req_o), 0);
    sw_write(5);
    sw_write(6);
    tick(10);
    cmp("deferred point", int'(tr_pt_o), 6);

    tag = "R3";
    hot_i = 1; tick(2); hot_i = 0; tick(1);
    hot_i = 1; tick(2); hot_i = 0; tick(3);
    cmp("short bursts ignored", int'(throttled_o), 0);

    tag = "R4";
    hot_i = 1;
    wait_thr(1);
    cmp("down request", int'(tr_req_o), 1);
    cmp("down point", int'(tr_pt_o), LOW);

    tag = "R8";
    wait_req(0);
    tick(1);
    cmp("down status", int'(irq_stat_o), 1);
    cmp("down irq", int'(irq_o), 1);

    tag = "R9";
    irq_clr_i = 2'b01; tick(1); irq_clr_i = 0; tick(1);
    cmp("cleared status", int'(irq_stat_o), 0);
    cmp("cleared irq", int'(irq_o), 0);

    tag = "R7";
    tick(40);
    cmp("still throttled", int'(throttled_o), 1);
    cmp("no request while hot", int'(tr_req_o), 0);

    tag = "R11";
    sw_write(7);
    tick(2);
    cmp("write during hold issues nothing", int'(tr_req_o), 0);

    tag = "R6";
    hot_i = 0;
    wait_req(1);
    cmp("restore point", int'(tr_pt_o), 7);
    wait_thr(0);
    cmp("restore status", int'(irq_stat_o[1]), 1);
    irq_clr_i = 2'b11; tick(1); irq_clr_i = 0; tick(2);

    tag = "R5";
    hot_i = 1;
    wait_thr(1);
    hot_i = 0;
    cnt = 0;
    for (int i = 0; i < 200 && throttled_o; i++) begin
      if (!tr_req_o) cnt++;
      @(negedge clk);
    end
    cmp("hold length", cnt, WAIT_CYC);

    tag = "R10";
    fail_mode = 1;
    hot_i = 1;
    wait_thr(1);
    wait_req(0);
    tick(1);
    cmp("duty fallback", int'(duty_en_o), 1);
    fail_mode = 0;
    hot_i = 0;
    wait_thr(0);
    tick(1);
    cmp("duty released", int'(duty_en_o), 0);
    irq_clr_i = 2'b11; tick(1); irq_clr_i = 0; tick(2);

    tag = "R12";
    fail_mode = 1;
    sw_write(3);
    tick(5);
    fail_mode = 0;
    tick(12);
    cmp("retried point", int'(tr_pt_o), 3);
    cmp("retry finished", int'(tr_req_o), 0);

    tag = "R3";
    cfg_qual_i = 0;
    hot_i = 1; tick(1); hot_i = 0;
    tick(2);
    cmp("zero count qualifies one sample", int'(throttled_o), 1);
    wait_thr(0);
    tick(4);

    finish_run();
  end
endmodule